// File: doc/BRIEF.md
# QoS-Priority Multi-Port SRAM Arbiter

This block shares one single-ported on-chip SRAM among fourteen host ports. Each port raises a request carrying a write flag, a word address, write data and byte strobes. In any cycle, the arbiter grants at most one port and forwards that port's access to the SRAM. Every port has a 2-bit quality-of-service level. The highest level wins. When levels are equal, the lower port number wins.

Ports at the two lowest levels pay one extra cycle of latency. A new request at level 0 or 1 becomes eligible only in the cycle after it first appears. Requests at level 2 or 3 can be granted in the cycle they arrive.

A small 32-bit register interface holds the levels. Most ports have a programmable level. Ports 8, 9 and 12 have a fixed level that software cannot change. Read data returns on a bus shared by all ports, and the port that issued the read gets a one-cycle read-valid pulse.

Top module: `qos_sram_arb`

## Requirements
- R1: Levels are 2 bits: 0 background, 1 bandwidth-sensitive, 2 latency-sensitive, 3 latency-critical. The level of port p is read at register word address p, in bits [1:0], and the upper bits read as zero.
- R2: After reset the levels are: port 0 = 3, ports 1, 2 and 4–7 = 2, port 3 = 1, ports 8–11 = 1, port 12 = 2, port 13 = 3.
- R3: A register write with all four byte strobes set (cfg_be = 4'hF) updates a programmable level. A write with any strobe clear leaves the level unchanged. A read with any strobe clear returns zero.
- R4: Writes to ports 8, 9 and 12 leave their fixed levels unchanged.
- R5: At most one port is granted per cycle, and only a port whose req_valid is high.
- R6: Among eligible requests, the one with the highest level is granted.
- R7: Among eligible requests of equal level, the lowest port number is granted.
- R8: A new request at level 0 or 1 is not granted in its first cycle and becomes eligible in the next cycle. A new request at level 2 or 3 can be granted in its first cycle.
- R9: In a grant cycle, mem_en is high and the SRAM bus carries the granted port's write flag, address, data and byte strobes.
- R10: A granted read produces a one-cycle rd_valid pulse on that port in the following cycle, with rd_data equal to the SRAM output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | NPORTS | Per-port request, held until granted |
| req_we | input | NPORTS | Per-port write flag |
| req_addr | input | NPORTS*AW | Per-port word address, packed |
| req_wdata | input | NPORTS*DW | Per-port write data, packed |
| req_be | input | NPORTS*DW/8 | Per-port byte strobes, packed |
| grant | output | NPORTS | One-hot grant, same cycle |
| rd_valid | output | NPORTS | Read data valid for the issuing port |
| rd_data | output | DW | Shared read data |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM word address |
| mem_wdata | output | DW | SRAM write data |
| mem_be | output | DW/8 | SRAM byte strobes |
| mem_rdata | input | DW | SRAM read data, one cycle after the access |
| cfg_en | input | 1 | Register access strobe |
| cfg_we | input | 1 | Register write |
| cfg_addr | input | CFG_AW | Register word address (port number) |
| cfg_be | input | 4 | Register byte strobes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |

## Verification
On every cycle, the assertions check four properties. The grant is one-hot or empty and goes only to a requesting port. A low-level grant always follows a cycle in which that port already had a request pending. Every read-valid pulse follows an SRAM read. A partial-strobe register write leaves every level unchanged. Priority order, the exact tie-break, the reset levels, fixed-port protection and correct data steering depend on specific request patterns and expected values, so only the bench's vector table and directed scenarios show them.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  localparam int QW = 2;
  typedef logic [QW-1:0] qos_t;
  typedef enum logic [QW-1:0] {
    QOS_BACKGROUND = 2'd0,
    QOS_BANDWIDTH  = 2'd1,
    QOS_LATENCY    = 2'd2,
    QOS_CRITICAL   = 2'd3
  } qos_lvl_e;
  localparam int CFG_DW = 32;
  localparam logic [3:0] CFG_FULL_BE = 4'hF;
endpackage

// File: rtl/qos_cfg_regs.sv
module qos_cfg_regs
  import qos_arb_pkg::*;
#(
  parameter int NPORTS = 14,
  parameter int CFG_AW = 4,
  parameter logic [NPORTS*QW-1:0] RST_QOS = '0,
  parameter logic [NPORTS-1:0] FIXED_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [3:0]           cfg_be,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  output logic [CFG_DW-1:0]    cfg_rdata,
  output logic [NPORTS*QW-1:0] qos_o
);
  logic full_acc;
  assign full_acc = cfg_en && (cfg_be == CFG_FULL_BE);

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    if (FIXED_MASK[p]) begin : g_fixed
      assign qos_o[p*QW +: QW] = RST_QOS[p*QW +: QW];
    end else begin : g_prog
      qos_t lvl_q, lvl_d;
      logic wr_hit;
      assign wr_hit = full_acc && cfg_we && (int'(cfg_addr) == p);
      always_comb begin
        lvl_d = lvl_q;
        if (wr_hit) lvl_d = cfg_wdata[QW-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= RST_QOS[p*QW +: QW];
        else if (wr_hit) lvl_q <= lvl_d;
      end
      assign qos_o[p*QW +: QW] = lvl_q;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (full_acc && !cfg_we && (int'(cfg_addr) < NPORTS))
      cfg_rdata[QW-1:0] = qos_o[int'(cfg_addr)*QW +: QW];
  end

  // R3
  narrow_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && cfg_we && cfg_be != CFG_FULL_BE) |=> $stable(qos_o));
endmodule

// File: rtl/qos_elig.sv
module qos_elig
  import qos_arb_pkg::*;
#(
  parameter int NPORTS = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    req_valid,
  input  logic [NPORTS-1:0]    grant,
  input  logic [NPORTS*QW-1:0] qos_i,
  output logic [NPORTS-1:0]    elig
);
  logic [NPORTS-1:0] seen_q, seen_d;

  always_comb begin
    seen_d = req_valid & ~grant;
    for (int p = 0; p < NPORTS; p++) begin
      elig[p] = req_valid[p] &&
                (qos_i[p*QW +: QW] >= QOS_LATENCY || seen_q[p]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R8
    low_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[p] && qos_i[p*QW +: QW] < QOS_LATENCY) |-> $past(req_valid[p]));
  end
endmodule

// File: rtl/qos_pick.sv
module qos_pick
  import qos_arb_pkg::*;
#(
  parameter int NPORTS = 14,
  localparam int IW = $clog2(NPORTS)
) (
  input  logic [NPORTS-1:0]    elig,
  input  logic [NPORTS*QW-1:0] qos_i,
  output logic [NPORTS-1:0]    grant,
  output logic [IW-1:0]        win_idx,
  output logic                 win_any
);
  qos_t best;
  always_comb begin
    best    = QOS_BACKGROUND;
    win_any = 1'b0;
    win_idx = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (elig[p] && (!win_any || qos_i[p*QW +: QW] > best)) begin
        win_any = 1'b1;
        best    = qos_i[p*QW +: QW];
        win_idx = IW'(p);
      end
    end
    grant = '0;
    if (win_any) grant[win_idx] = 1'b1;
  end
endmodule

// File: rtl/qos_sram_arb.sv
module qos_sram_arb
  import qos_arb_pkg::*;
#(
  parameter int NPORTS = 14,
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CFG_AW = 4,
  parameter logic [NPORTS*QW-1:0] RST_QOS = 28'hE55AA6B,
  parameter logic [NPORTS-1:0] FIXED_MASK = 14'h1300,
  localparam int BW = DW / 8,
  localparam int IW = $clog2(NPORTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORTS-1:0]    req_valid,
  input  logic [NPORTS-1:0]    req_we,
  input  logic [NPORTS*AW-1:0] req_addr,
  input  logic [NPORTS*DW-1:0] req_wdata,
  input  logic [NPORTS*BW-1:0] req_be,
  output logic [NPORTS-1:0]    grant,
  output logic [NPORTS-1:0]    rd_valid,
  output logic [DW-1:0]        rd_data,
  output logic                 mem_en,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [DW-1:0]        mem_wdata,
  output logic [BW-1:0]        mem_be,
  input  logic [DW-1:0]        mem_rdata,
  input  logic                 cfg_en,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata
);
  logic [1:0] rst_sync_q;
  logic rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [NPORTS*QW-1:0] qos;
  logic [NPORTS-1:0]    elig;
  logic [IW-1:0]        win_idx;
  logic                 win_any;

  qos_cfg_regs #(
    .NPORTS(NPORTS), .CFG_AW(CFG_AW), .RST_QOS(RST_QOS), .FIXED_MASK(FIXED_MASK)
  ) u_regs (
    .clk(clk), .rst_n(rst_ni), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .qos_o(qos)
  );

  qos_elig #(.NPORTS(NPORTS)) u_elig (
    .clk(clk), .rst_n(rst_ni), .req_valid(req_valid), .grant(grant),
    .qos_i(qos), .elig(elig)
  );

  qos_pick #(.NPORTS(NPORTS)) u_pick (
    .elig(elig), .qos_i(qos), .grant(grant), .win_idx(win_idx), .win_any(win_any)
  );

  always_comb begin
    mem_en    = win_any;
    mem_we    = req_we[win_idx];
    mem_addr  = req_addr[win_idx*AW +: AW];
    mem_wdata = req_wdata[win_idx*DW +: DW];
    mem_be    = req_be[win_idx*BW +: BW];
  end

  logic [NPORTS-1:0] rd_pend_q, rd_pend_d;
  assign rd_pend_d = grant & ~req_we;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rd_pend_q <= '0;
    else         rd_pend_q <= rd_pend_d;
  end
  assign rd_valid = rd_pend_q;
  assign rd_data  = mem_rdata;

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(grant));
  // R5
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (grant & ~req_valid) == '0);
  // R10
  rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (|rd_valid) |-> ($onehot(rd_valid) && $past(mem_en && !mem_we)));
endmodule

// File: tb/sim_qos_sram_arb.sv
module sim_qos_sram_arb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 14;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int NVEC = 10;
  localparam int NONE = 15;

  // {request mask, expected winner in first cycle, expected winner in second cycle}
  localparam logic [21:0] VEC [NVEC] = '{
    {14'h2001, 4'd0,  4'd0 },  // R6 level 3 vs level 3, tie -> port 0 (R7)
    {14'h3000, 4'd13, 4'd13},  // R6 level 3 beats level 2
    {14'h1002, 4'd1,  4'd1 },  // R7 equal level 2 -> lower port
    {14'h0300, 4'd15, 4'd8 },  // R8 level 1 waits, then R7
    {14'h1100, 4'd12, 4'd12},  // R6 level 2 beats level 1
    {14'h0018, 4'd4,  4'd4 },  // R6 port 4 (2) beats port 3 (1)
    {14'h0C00, 4'd15, 4'd10},  // R8 level 1 pair
    {14'h2000, 4'd13, 4'd13},  // R8 level 3 same cycle
    {14'h000E, 4'd1,  4'd1 },  // R7 three requesters
    {14'h0108, 4'd15, 4'd3 }   // R8 then R7 among level 1
  };

  logic clk, rst_n;
  logic [N-1:0] req_valid, req_we, grant, rd_valid;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata;
  logic [N*BW-1:0] req_be;
  logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [BW-1:0] mem_be;
  logic cfg_en, cfg_we;
  logic [3:0] cfg_addr, cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  int n_chk, n_bad, cyc;
  logic [DW-1:0] sram [2**AW];

  qos_sram_arb u0 (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < BW; b++)
          if (mem_be[b]) sram[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end else begin
        mem_rdata <= sram[mem_addr];
      end
    end
  end

  function automatic int gidx(input logic [N-1:0] g);
    int r = NONE;
    for (int p = N-1; p >= 0; p--) if (g[p]) r = p;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [N-1:0] m, input logic we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [BW-1:0] be);
    req_valid = m;
    req_we = '0; req_addr = '0; req_wdata = '0; req_be = '0;
    for (int p = 0; p < N; p++) begin
      req_we[p] = we;
      req_addr[p*AW +: AW] = a;
      req_wdata[p*DW +: DW] = d;
      req_be[p*BW +: BW] = be;
    end
  endtask

  task automatic idle2();
    drive('0, 1'b0, '0, '0, '0);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_en = 1; cfg_we = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_en = 0; cfg_we = 0;
  endtask

  function automatic logic [31:0] cfg_rd_now(input logic [3:0] a, input logic [3:0] be);
    cfg_en = 1; cfg_we = 0; cfg_addr = a; cfg_be = be;
    return 32'h0;
  endfunction

  task automatic cfg_rd(input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
    cfg_en = 1; cfg_we = 0; cfg_addr = a; cfg_be = be;
    #1 d = cfg_rdata;
    cfg_en = 0;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    logic [3:0] rst_lvl [N] = '{3,2,2,1,2,2,2,2,1,1,1,1,2,3};
    n_chk = 0; n_bad = 0;
    rst_n = 0; cfg_en = 0; cfg_we = 0; cfg_addr = 0; cfg_be = 0; cfg_wdata = 0;
    mem_rdata = '0;
    drive('0, 1'b0, '0, '0, '0);
    for (int i = 0; i < 2**AW; i++) sram[i] = '0;
    repeat (3) @(negedge clk);
    chk("R5 reset grant", 32'(grant), 0);
    chk("R10 reset rd_valid", 32'(rd_valid), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 R1 reset levels through register reads
    for (int p = 0; p < N; p++) begin
      cfg_rd(4'(p), 4'hF, rd);
      chk("R2 reset level", rd, 32'(rst_lvl[p]));
    end

    // Vector table: requests appear from idle, winner checked in two cycles
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      drive(VEC[v][21:8], 1'b0, 8'(v), '0, 4'hF);
      #1 chk("R6/R7/R8 first cycle", 32'(gidx(grant)), 32'(VEC[v][7:4]));
      @(negedge clk);
      #1 chk("R6/R7/R8 second cycle", 32'(gidx(grant)), 32'(VEC[v][3:0]));
      idle2();
    end

    // R3 full write then narrow write ignored, narrow read zero
    cfg_wr(4'd13, 4'hF, 32'hFFFF_FFF0);
    cfg_rd(4'd13, 4'hF, rd);
    chk("R3 full write", rd, 32'd0);
    cfg_wr(4'd13, 4'h3, 32'h3);
    cfg_rd(4'd13, 4'hF, rd);
    chk("R3 narrow write ignored", rd, 32'd0);
    cfg_rd(4'd0, 4'h1, rd);
    chk("R3 narrow read zero", rd, 32'd0);
    // R4 fixed port
    cfg_wr(4'd12, 4'hF, 32'h0);
    cfg_rd(4'd12, 4'hF, rd);
    chk("R4 fixed level kept", rd, 32'd2);

    // R8 port 13 now level 0 must wait a cycle
    @(negedge clk);
    drive(14'h2000, 1'b0, '0, '0, 4'hF);
    #1 chk("R8 level 0 first cycle", 32'(gidx(grant)), NONE);
    @(negedge clk);
    #1 chk("R8 level 0 second cycle", 32'(gidx(grant)), 13);
    idle2();
    // R6 port 12 at 2 now beats port 13 at 0
    @(negedge clk);
    drive(14'h3000, 1'b0, '0, '0, 4'hF);
    @(negedge clk);
    #1 chk("R6 after reprogram", 32'(gidx(grant)), 12);
    idle2();

    // R9 write steering with byte strobes
    @(negedge clk);
    drive(14'h0020, 1'b1, 8'd7, 32'hA5A5_1234, 4'hF);
    #1;
    chk("R9 grant", 32'(grant), 32'h20);
    chk("R9 mem_we", 32'(mem_we), 1);
    chk("R9 mem_addr", 32'(mem_addr), 7);
    chk("R9 mem_wdata", mem_wdata, 32'hA5A5_1234);
    @(negedge clk);
    drive(14'h0020, 1'b1, 8'd7, 32'h0000_00FF, 4'b0001);
    #1 chk("R9 mem_be", 32'(mem_be), 32'h1);
    @(negedge clk);
    drive('0, 1'b0, '0, '0, '0);
    #1 chk("R10 no rd_valid after write", 32'(rd_valid), 0);

    // R10 read return
    @(negedge clk);
    drive(14'h0040, 1'b0, 8'd7, '0, 4'hF);
    #1 chk("R10 read grant", 32'(grant), 32'h40);
    @(negedge clk);
    drive('0, 1'b0, '0, '0, '0);
    #1;
    chk("R10 rd_valid", 32'(rd_valid), 32'h40);
    chk("R10 rd_data", rd_data, 32'hA5A5_12FF);
    @(negedge clk);
    #1 chk("R10 rd_valid single pulse", 32'(rd_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule